// File: doc/BRIEF.md
# Bidirectional Latched/Registered Bus Transceiver

This block links two 18-bit tri-state buses, an A side and a B side, with one storage path per direction. Each path passes its source bus straight through, holds a captured word, or loads a new word on a clock edge. Which of these it does depends on that direction's latch-enable and clock inputs. A separate output-enable input for each direction decides whether the stored or passing word is driven onto the far bus, or whether that bus is released.

The A-to-B enable is asserted high and the B-to-A enable is asserted low. The two paths share no state, so each direction can hold its own word at the same time. Each driver also reports its drive state on a plain output, so that a disabled bus can be recognised without relying on high-impedance values. After power-up a path's contents are unknown until it has been loaded through transparency or by a clock edge.

Top module: `dual_path_xcvr`

## Requirements
- R1: Both directions carry all 18 bits. An all-ones word, an all-zeros word, alternating patterns and a word with only bit 17 set each arrive intact at the far bus.
- R2: While `le_ab` is 1, the word on `b_bus` follows `a_bus` every time `a_bus` changes, provided `oe_ab` is 1.
- R3: While `le_ab` is 0, a 1-to-0 transition of `clk_ab_n` loads the current `a_bus` word into the A-to-B path, and `b_bus` shows that word.
- R4: In either direction, while the latch enable is 0, a change of the source bus, a 0-to-1 clock transition or a clock held at a steady level leaves the far bus unchanged.
- R5: When `oe_ab` is 1, the block drives `b_bus` and `b_drive_en` is 1. When `oe_ab` is 0, `b_drive_en` is 0 and the block releases `b_bus`, so another driver can set any word on it.
- R6: While `le_ba` is 1, `a_bus` follows `b_bus`, provided `oe_ba_n` is 0.
- R7: While `le_ba` is 0, a 1-to-0 transition of `clk_ba_n` loads the current `b_bus` word into the B-to-A path, and `a_bus` shows that word.
- R8: When `oe_ba_n` is 0, the block drives `a_bus` and `a_drive_en` is 1. When `oe_ba_n` is 1, `a_drive_en` is 0 and `a_bus` is released.
- R9: A 1-to-0 clock transition while the latch enable is 1 has no separate effect. The output keeps following the live source word after that edge.
- R10: When the latch enable goes from 1 to 0, the path keeps the source word present at that moment. Later changes of the source bus have no effect.
- R11: The two paths are independent. With both latch enables 0 and both buses driven by the block, `b_bus` shows the word loaded into the A-to-B path and `a_bus` shows the different word loaded into the B-to-A path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_bus | inout | 18 | A-side bus: source for A-to-B, driven by the B-to-A path |
| b_bus | inout | 18 | B-side bus: source for B-to-A, driven by the A-to-B path |
| le_ab | input | 1 | A-to-B latch enable, 1 = transparent |
| clk_ab_n | input | 1 | A-to-B clock, loads on the 1-to-0 transition |
| oe_ab | input | 1 | A-to-B output enable, 1 = drive `b_bus` |
| le_ba | input | 1 | B-to-A latch enable, 1 = transparent |
| clk_ba_n | input | 1 | B-to-A clock, loads on the 1-to-0 transition |
| oe_ba_n | input | 1 | B-to-A output enable, 0 = drive `a_bus` |
| b_drive_en | output | 1 | 1 while the block drives `b_bus` |
| a_drive_en | output | 1 | 1 while the block drives `a_bus` |

## Verification
The hardest state to reach is a path whose output depends on the order of recent events. One case is a path that has taken a clock edge while transparent and then has its latch enable dropped. Another is a path that has taken several edges since its latch enable fell. Each directed task first loads the path through transparency. It then issues clock transitions and source-bus changes one at a time, with the far bus checked after each, so that a wrong choice among live word, held word and clocked word shows at once. For independence, both paths are loaded with different words and then both buses are released by the bench together.

// File: rtl/dual_path_xcvr_pkg.sv
package dual_path_xcvr_pkg;

  // Which stored or live word a path presents on its far bus.
  typedef enum logic [1:0] {
    SRC_LIVE  = 2'd0,
    SRC_LATCH = 2'd1,
    SRC_FLOP  = 2'd2
  } path_src_e;

  // Transparent while enabled; after the enable drops, the held word
  // is shown until a clock edge has loaded a newer one.
  function automatic path_src_e pick_src(input logic le, input logic edge_seen);
    if (le)             return SRC_LIVE;
    else if (edge_seen) return SRC_FLOP;
    else                return SRC_LATCH;
  endfunction

  // Decodes an output-enable pin of either polarity.
  function automatic logic oe_asserted(input logic pin, input logic active_high);
    return active_high ? pin : ~pin;
  endfunction

endpackage

// File: rtl/dual_path_xcvr_store.sv
module dual_path_xcvr_store
  import dual_path_xcvr_pkg::*;
#(
  parameter int W = 18
) (
  input  logic [W-1:0] din,
  input  logic         le,
  input  logic         clk_n,
  output logic [W-1:0] dout,
  output logic         edge_sel,
  output path_src_e    src
);

  logic [W-1:0] lat_q;
  logic [W-1:0] flop_q;

  // Level-sensitive half: keeps the word present when le falls.
  always_latch begin
    if (le) lat_q <= din;
  end

  // Edge half: loads on every falling clock edge. Its word is only shown
  // once edge_sel records an edge taken while le was low.
  always_ff @(negedge clk_n) begin
    flop_q <= din;
  end

  // Set by a falling edge with le low, cleared while le is high.
  always_ff @(negedge clk_n or posedge le) begin
    if (le) edge_sel <= 1'b0;
    else    edge_sel <= 1'b1;
  end

  assign src = pick_src(le, edge_sel);

  always_comb begin
    case (src)
      SRC_LIVE: dout = din;
      SRC_FLOP: dout = flop_q;
      default:  dout = lat_q;
    endcase
  end

endmodule

// File: rtl/dual_path_xcvr_drv.sv
module dual_path_xcvr_drv
  import dual_path_xcvr_pkg::*;
#(
  parameter int W           = 18,
  parameter bit ACTIVE_HIGH = 1'b1
) (
  input  logic [W-1:0] val,
  input  logic         oe_pin,
  output logic         drv_en,
  inout  wire  [W-1:0] pad
);

  assign drv_en = oe_asserted(oe_pin, ACTIVE_HIGH);
  assign pad    = drv_en ? val : {W{1'bz}};

endmodule

// File: rtl/dual_path_xcvr.sv
module dual_path_xcvr
  import dual_path_xcvr_pkg::*;
#(
  parameter int W = 18
) (
  inout  wire  [W-1:0] a_bus,
  inout  wire  [W-1:0] b_bus,
  input  logic         le_ab,
  input  logic         clk_ab_n,
  input  logic         oe_ab,
  input  logic         le_ba,
  input  logic         clk_ba_n,
  input  logic         oe_ba_n,
  output logic         b_drive_en,
  output logic         a_drive_en
);

  // Named internal wires, used by the bound checker.
  logic [W-1:0] ab_q;
  logic [W-1:0] ba_q;
  logic         ab_edge_sel;
  logic         ba_edge_sel;
  path_src_e    ab_src;
  path_src_e    ba_src;

  dual_path_xcvr_store #(.W(W)) u_ab_store (
    .din      (a_bus),
    .le       (le_ab),
    .clk_n    (clk_ab_n),
    .dout     (ab_q),
    .edge_sel (ab_edge_sel),
    .src      (ab_src)
  );

  dual_path_xcvr_store #(.W(W)) u_ba_store (
    .din      (b_bus),
    .le       (le_ba),
    .clk_n    (clk_ba_n),
    .dout     (ba_q),
    .edge_sel (ba_edge_sel),
    .src      (ba_src)
  );

  dual_path_xcvr_drv #(.W(W), .ACTIVE_HIGH(1'b1)) u_b_drv (
    .val    (ab_q),
    .oe_pin (oe_ab),
    .drv_en (b_drive_en),
    .pad    (b_bus)
  );

  dual_path_xcvr_drv #(.W(W), .ACTIVE_HIGH(1'b0)) u_a_drv (
    .val    (ba_q),
    .oe_pin (oe_ba_n),
    .drv_en (a_drive_en),
    .pad    (a_bus)
  );

endmodule

// File: rtl/dual_path_xcvr_chk.sv
module dual_path_xcvr_chk #(
  parameter int W = 18
) (
  input wire  [W-1:0] a_bus,
  input wire  [W-1:0] b_bus,
  input logic         le_ab,
  input logic         clk_ab_n,
  input logic         oe_ab,
  input logic         le_ba,
  input logic         clk_ba_n,
  input logic         oe_ba_n,
  input logic         b_drive_en,
  input logic         a_drive_en,
  input logic [W-1:0] ab_q,
  input logic [W-1:0] ba_q,
  input logic         ab_edge_sel,
  input logic         ba_edge_sel
);

  // R2: transparent A-to-B path matches the source bus on the far bus.
  assert_ab_transparent_R2: assert property (
    @(negedge clk_ab_n) (le_ab && oe_ab) |-> (b_bus == a_bus));

  // R3: after a falling edge with le low, the path holds the word sampled there.
  assert_ab_edge_load_R3: assert property (
    @(negedge clk_ab_n) (!le_ab) |=> (le_ab || !ab_edge_sel || ab_q == $past(a_bus)));

  // R5: B driver state follows the active-high enable.
  assert_b_enable_R5: assert property (
    @(negedge clk_ab_n) (b_drive_en == oe_ab));

  // R6: transparent B-to-A path.
  assert_ba_transparent_R6: assert property (
    @(negedge clk_ba_n) (le_ba && !oe_ba_n) |-> (a_bus == b_bus));

  // R7: B-to-A edge load.
  assert_ba_edge_load_R7: assert property (
    @(negedge clk_ba_n) (!le_ba) |=> (le_ba || !ba_edge_sel || ba_q == $past(b_bus)));

  // R8: A driver state follows the active-low enable.
  assert_a_enable_R8: assert property (
    @(negedge clk_ba_n) (a_drive_en == !oe_ba_n));

endmodule

bind dual_path_xcvr dual_path_xcvr_chk #(.W(W)) u_chk (
  .a_bus       (a_bus),
  .b_bus       (b_bus),
  .le_ab       (le_ab),
  .clk_ab_n    (clk_ab_n),
  .oe_ab       (oe_ab),
  .le_ba       (le_ba),
  .clk_ba_n    (clk_ba_n),
  .oe_ba_n     (oe_ba_n),
  .b_drive_en  (b_drive_en),
  .a_drive_en  (a_drive_en),
  .ab_q        (ab_q),
  .ba_q        (ba_q),
  .ab_edge_sel (ab_edge_sel),
  .ba_edge_sel (ba_edge_sel)
);

// File: tb/dual_path_xcvr_test.sv
`timescale 1ns/1ps
module dual_path_xcvr_test;
  localparam int W = 18;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         le_ab, clk_ab_n, oe_ab, le_ba, clk_ba_n, oe_ba_n;
  logic         b_drive_en, a_drive_en;
  logic [W-1:0] tb_a, tb_b;
  logic         tb_a_en, tb_b_en;
  wire  [W-1:0] a_bus, b_bus;

  assign a_bus = tb_a_en ? tb_a : {W{1'bz}};
  assign b_bus = tb_b_en ? tb_b : {W{1'bz}};

  dual_path_xcvr #(.W(W)) uut (
    .a_bus(a_bus), .b_bus(b_bus),
    .le_ab(le_ab), .clk_ab_n(clk_ab_n), .oe_ab(oe_ab),
    .le_ba(le_ba), .clk_ba_n(clk_ba_n), .oe_ba_n(oe_ba_n),
    .b_drive_en(b_drive_en), .a_drive_en(a_drive_en)
  );

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  done     = 1'b0;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic settle();
    #3;
  endtask

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // dir 0: A-to-B (bench drives A, reads B); dir 1: B-to-A.
  task automatic setup_dir(input bit dir);
    tick();
    if (!dir) begin
      oe_ba_n = 1'b1; tb_b_en = 1'b0; tb_a_en = 1'b1; oe_ab = 1'b1;
    end else begin
      oe_ab = 1'b0; tb_a_en = 1'b0; tb_b_en = 1'b1; oe_ba_n = 1'b0;
    end
    settle();
  endtask

  task automatic put_src(input bit dir, input logic [W-1:0] v);
    tick();
    if (!dir) tb_a = v; else tb_b = v;
    settle();
  endtask

  task automatic set_le(input bit dir, input logic v);
    tick();
    if (!dir) le_ab = v; else le_ba = v;
    settle();
  endtask

  task automatic set_clk(input bit dir, input logic v);
    tick();
    if (!dir) clk_ab_n = v; else clk_ba_n = v;
    settle();
  endtask

  function automatic logic [W-1:0] far_bus(input bit dir);
    return dir ? a_bus : b_bus;
  endfunction

  task automatic t_idle();
    tick();
    le_ab = 1'b0; le_ba = 1'b0; clk_ab_n = 1'b1; clk_ba_n = 1'b1;
    oe_ab = 1'b0; oe_ba_n = 1'b1; tb_a_en = 1'b0; tb_b_en = 1'b0;
    tb_a = '0; tb_b = '0;
    settle();
    chk("R5 idle b_drive_en", {17'd0, b_drive_en}, 18'd0);
    chk("R8 idle a_drive_en", {17'd0, a_drive_en}, 18'd0);
  endtask

  task automatic t_transparent(input bit dir);
    logic [W-1:0] pats [5];
    string rq;
    pats[0] = 18'h3FFFF; pats[1] = 18'h00000; pats[2] = 18'h2AAAA;
    pats[3] = 18'h15555; pats[4] = 18'h20000;
    rq = dir ? "R6" : "R2";
    setup_dir(dir);
    set_le(dir, 1'b1);
    for (int i = 0; i < 5; i++) begin
      put_src(dir, pats[i]);
      chk({rq, " R1 follow"}, far_bus(dir), pats[i]);
    end
    if (!dir) chk("R5 b_drive_en on", {17'd0, b_drive_en}, 18'd1);
    else      chk("R8 a_drive_en on", {17'd0, a_drive_en}, 18'd1);
  endtask

  task automatic t_edge_load(input bit dir, input logic [W-1:0] x, input logic [W-1:0] y);
    string rq;
    rq = dir ? "R7" : "R3";
    setup_dir(dir);
    set_le(dir, 1'b1);
    put_src(dir, 18'h00F0F);
    set_le(dir, 1'b0);
    put_src(dir, x);
    chk("R4 le low ignores source", far_bus(dir), 18'h00F0F);
    set_clk(dir, 1'b0);
    chk({rq, " falling edge load"}, far_bus(dir), x);
    put_src(dir, y);
    chk("R4 clock held low", far_bus(dir), x);
    set_clk(dir, 1'b1);
    chk("R4 rising edge no load", far_bus(dir), x);
    set_clk(dir, 1'b0);
    chk({rq, " second edge load"}, far_bus(dir), y);
    set_clk(dir, 1'b1);
  endtask

  task automatic t_le_fall(input bit dir, input logic [W-1:0] p, input logic [W-1:0] q,
                           input logic [W-1:0] r);
    setup_dir(dir);
    set_le(dir, 1'b1);
    put_src(dir, p);
    set_clk(dir, 1'b0);
    set_clk(dir, 1'b1);
    put_src(dir, q);
    chk("R9 edge while transparent", far_bus(dir), q);
    set_le(dir, 1'b0);
    chk("R10 held at le fall", far_bus(dir), q);
    put_src(dir, r);
    chk("R10 later source ignored", far_bus(dir), q);
  endtask

  task automatic t_oe_ab();
    setup_dir(1'b0);
    set_le(1'b1, 1'b0);
    set_le(1'b0, 1'b1);
    put_src(1'b0, 18'h0C3C3);
    set_le(1'b0, 1'b0);
    tick(); oe_ab = 1'b0; settle();
    chk("R5 disabled b_drive_en", {17'd0, b_drive_en}, 18'd0);
    tick(); tb_b = 18'h31234; tb_b_en = 1'b1; settle();
    chk("R5 B released to bench", b_bus, 18'h31234);
    tick(); tb_b_en = 1'b0; oe_ab = 1'b1; settle();
    chk("R5 re-enabled drives held", b_bus, 18'h0C3C3);
  endtask

  task automatic t_oe_ba();
    setup_dir(1'b1);
    set_le(1'b1, 1'b1);
    put_src(1'b1, 18'h2F00F);
    set_le(1'b1, 1'b0);
    tick(); oe_ba_n = 1'b1; settle();
    chk("R8 disabled a_drive_en", {17'd0, a_drive_en}, 18'd0);
    tick(); tb_a = 18'h05A5A; tb_a_en = 1'b1; settle();
    chk("R8 A released to bench", a_bus, 18'h05A5A);
    tick(); tb_a_en = 1'b0; oe_ba_n = 1'b0; settle();
    chk("R8 re-enabled drives held", a_bus, 18'h2F00F);
  endtask

  task automatic t_independent();
    setup_dir(1'b0);
    set_le(1'b0, 1'b1);
    put_src(1'b0, 18'h1ABCD);
    set_le(1'b0, 1'b0);
    setup_dir(1'b1);
    set_le(1'b1, 1'b0);
    put_src(1'b1, 18'h26543);
    set_clk(1'b1, 1'b0);
    set_clk(1'b1, 1'b1);
    tick();
    tb_a_en = 1'b0; tb_b_en = 1'b0; oe_ab = 1'b1; oe_ba_n = 1'b0;
    settle();
    chk("R11 B shows A-to-B word", b_bus, 18'h1ABCD);
    chk("R11 A shows B-to-A word", a_bus, 18'h26543);
    tick(); oe_ab = 1'b0; oe_ba_n = 1'b1; settle();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
  endtask

  initial begin
    t_idle();
    t_transparent(1'b0);
    t_transparent(1'b1);
    t_edge_load(1'b0, 18'h12345, 18'h3CAFE);
    t_edge_load(1'b1, 18'h2BEEF, 18'h01357);
    t_le_fall(1'b0, 18'h11111, 18'h22222, 18'h33333);
    t_le_fall(1'b1, 18'h0AAAA, 18'h35555, 18'h1F0F0);
    t_oe_ab();
    t_oe_ba();
    t_independent();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule